// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt requests from a small group of core sources and a larger group of peripheral sources into a sixteen-slot pending register. Each pending slot is qualified by a mask register and a global enable. The block then offers the highest-priority qualified slot to the processor core, together with its slot number and its vector address. A lower slot index always has the higher priority.

The core answers with an acknowledge strobe when it takes the offered interrupt and with a return strobe when the service routine ends. The block keeps an in-service set so that it knows the priority level being serviced. In nested mode, only a strictly higher-priority slot may interrupt the current service. In sequential mode, nothing is offered until every service has returned.

Software uses a single write port to set the control bits and the mask. Through the same port it can overwrite the pending register, which forces or clears requests. Peripheral sources with a priority of eleven or more share the last slot and its vector. Three reserved core slots ignore the mask, and two of those three also ignore the global enable.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, pending, in_service, mask, nesting and global enable are all zero, and irq_valid is low.
- R2: A rising edge on a request line sets its pending slot at the next clock, and a request held high sets it only once. Core line c maps to slot c. Peripheral line p maps to slot 4+p for p<11 and to slot 15 for p>=11.
- R3: A pending slot is eligible only when its mask bit is set (wr_sel=1 writes the mask), except slots 0, 1 and 2, which ignore the mask.
- R4: Control bit 5 (written with wr_sel=0) is the global enable. While it is clear, only slots 0 (emulation) and 1 (reset) can be offered, and slot 2 (power-down) is held back.
- R5: irq_slot is the lowest-index eligible slot, and irq_vec equals irq_slot×0x20, so slot 15 gives 0x1E0. Both read zero while irq_valid is low.
- R6: A write with wr_sel=2 replaces the pending register with wr_data, which forces or clears requests. A request edge in the same cycle still sets its slot.
- R7: irq_ack while irq_valid is high clears the offered pending bit and sets that slot's in_service bit at the next clock. irq_ack while irq_valid is low has no effect.
- R8: While in_service is non-zero, a slot is offered only if control bit 4 (nesting) is set and the slot index is strictly lower than the lowest in_service index.
- R9: irq_rti clears the lowest-index in_service bit, which returns the block to the previous service level.
- R10: Control bits other than 4 and 5 are ignored, and wr_sel=3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 4 | Core request lines for slots 0..3 |
| periph_req | input | 15 | Peripheral request lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 mask, 2 pending, 3 none |
| wr_data | input | 16 | Write data |
| irq_ack | input | 1 | Core takes the offered interrupt |
| irq_rti | input | 1 | Core returns from the current service |
| irq_valid | output | 1 | An interrupt is offered |
| irq_slot | output | 4 | Offered slot number |
| irq_vec | output | 24 | Offered vector address |
| pending | output | 16 | Pending register |
| in_service | output | 16 | Slots currently in service |

## Verification
Request edges, writes, acknowledges and returns all act on the next rising edge. irq_valid, irq_slot and irq_vec are decoded directly from registered state, so they are correct in the same cycle as that state. The bench therefore drives inputs just after a falling edge. It compares every output with its behavioural model at the following falling edge, which is one full register stage after the stimulus. The directed checks read the outputs at that same point.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_MASK = 2'd1,
      SEL_PEND = 2'd2,
      SEL_NONE = 2'd3
   } wr_sel_e;

   localparam int CTRL_NEST_BIT = 4;
   localparam int CTRL_GIE_BIT  = 5;

   // Peripheral line to slot: own slot below the shared priority, else last slot
   function automatic int periph_slot(input int p, input int core_n, input int num_slots);
      int share_prio;
      share_prio = num_slots - 1 - core_n;
      return (p < share_prio) ? (core_n + p) : (num_slots - 1);
   endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("irq_prio_pick: N must be at least 2");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_src_map.sv
module irq_src_map #(
   parameter int NUM_SLOTS   = 16,
   parameter int CORE_N      = 4,
   parameter int PERIPH_N    = 15,
   parameter bit LEVEL_SENSE = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CORE_N-1:0]    core_req,
   input  logic [PERIPH_N-1:0]  periph_req,
   output logic [NUM_SLOTS-1:0] set_vec
);
   import irq_pkg::*;

   logic [NUM_SLOTS-1:0] slot_in;

   always_comb begin
      slot_in = '0;
      for (int c = 0; c < CORE_N; c++) slot_in[c] = core_req[c];
      for (int p = 0; p < PERIPH_N; p++)
         slot_in[periph_slot(p, CORE_N, NUM_SLOTS)] = slot_in[periph_slot(p, CORE_N, NUM_SLOTS)] | periph_req[p];
   end

   if (LEVEL_SENSE) begin : g_level
      assign set_vec = slot_in;
   end else begin : g_edge
      logic [NUM_SLOTS-1:0] prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= '0;
         else        prev_q <= slot_in;
      end
      assign set_vec = slot_in & ~prev_q;

      // R2: a held request produces no second set pulse
      a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec != '0 |=> (set_vec & $past(slot_in)) == '0);
   end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [IDX_W-1:0] push_idx,
   input  logic             pop,
   output logic [N-1:0]     insvc,
   output logic             busy,
   output logic [IDX_W-1:0] cur_idx
);
   logic [N-1:0] insvc_q;
   logic [N-1:0] after_pop;
   logic [N-1:0] push_bit;

   // lowest set bit is the most recent (highest priority) service
   assign after_pop = pop ? (insvc_q & (insvc_q - N'(1))) : insvc_q;
   assign push_bit  = push ? (N'(1) << push_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) insvc_q <= '0;
      else        insvc_q <= after_pop | push_bit;
   end

   irq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_cur (
      .req   (insvc_q),
      .found (busy),
      .idx   (cur_idx)
   );

   assign insvc = insvc_q;

   // R9: a return without a new entry drops exactly one level
   a_r9_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
      pop && !push && busy |=> $countones(insvc_q) == $countones($past(insvc_q)) - 1);

   // R7: an accepted interrupt is recorded as in service
   a_r7_push_sets: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> insvc_q[$past(push_idx)]);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
   parameter int                 NUM_SLOTS   = 16,
   parameter int                 CORE_N      = 4,
   parameter int                 PERIPH_N    = 15,
   parameter int                 VEC_W       = 24,
   parameter int                 VEC_SHIFT   = 5,
   parameter logic [VEC_W-1:0]   VEC_BASE    = '0,
   parameter logic [NUM_SLOTS-1:0] NMI_SLOTS  = 16'h0007,
   parameter logic [NUM_SLOTS-1:0] GIE_BYPASS = 16'h0003,
   parameter bit                 LEVEL_SENSE = 1'b0,
   localparam int                IDX_W       = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CORE_N-1:0]    core_req,
   input  logic [PERIPH_N-1:0]  periph_req,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [NUM_SLOTS-1:0] wr_data,
   input  logic                 irq_ack,
   input  logic                 irq_rti,
   output logic                 irq_valid,
   output logic [IDX_W-1:0]     irq_slot,
   output logic [VEC_W-1:0]     irq_vec,
   output logic [NUM_SLOTS-1:0] pending,
   output logic [NUM_SLOTS-1:0] in_service
);
   import irq_pkg::*;

   if (NUM_SLOTS <= CORE_N + 1)           begin : g_bad_slots $error("slots must exceed core lines"); end
   if (NUM_SLOTS < CTRL_GIE_BIT + 1)      begin : g_bad_ctrl  $error("data too narrow for control bits"); end
   if (VEC_W < IDX_W + VEC_SHIFT)         begin : g_bad_vec   $error("vector width too small"); end
   if ((GIE_BYPASS & ~NMI_SLOTS) != '0)   begin : g_bad_nmi   $error("bypass slots must be non-maskable"); end

   wr_sel_e              sel;
   logic                 nest_q, gie_q;
   logic [NUM_SLOTS-1:0] mask_q, pend_q, pend_n;
   logic [NUM_SLOTS-1:0] set_vec, eligible, gie_gate;
   logic                 cand_found;
   logic [IDX_W-1:0]     cand_idx;
   logic                 svc_busy;
   logic [IDX_W-1:0]     svc_cur;
   logic                 take;
   logic                 wr_pend;

   assign sel     = wr_sel_e'(wr_sel);
   assign wr_pend = wr_en && (sel == SEL_PEND);

   irq_src_map #(
      .NUM_SLOTS(NUM_SLOTS), .CORE_N(CORE_N), .PERIPH_N(PERIPH_N), .LEVEL_SENSE(LEVEL_SENSE)
   ) u_src (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .periph_req(periph_req), .set_vec(set_vec)
   );

   // control and mask registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nest_q <= 1'b0;
         gie_q  <= 1'b0;
         mask_q <= '0;
      end else if (wr_en) begin
         if (sel == SEL_CTRL) begin
            nest_q <= wr_data[CTRL_NEST_BIT];
            gie_q  <= wr_data[CTRL_GIE_BIT];
         end
         if (sel == SEL_MASK) mask_q <= wr_data;
      end
   end

   // qualification and selection
   assign gie_gate = gie_q ? '1 : GIE_BYPASS;
   assign eligible = pend_q & (mask_q | NMI_SLOTS) & gie_gate;

   irq_prio_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
      .req(eligible), .found(cand_found), .idx(cand_idx)
   );

   always_comb begin
      if (!svc_busy) irq_valid = cand_found;
      else           irq_valid = cand_found && nest_q && (cand_idx < svc_cur);
   end

   assign irq_slot = irq_valid ? cand_idx : '0;
   assign irq_vec  = irq_valid ? (VEC_BASE + (VEC_W'(cand_idx) << VEC_SHIFT)) : '0;
   assign take     = irq_ack && irq_valid;

   // pending register: write, then acknowledge clear, then new edges
   always_comb begin
      pend_n = wr_pend ? wr_data : pend_q;
      if (take) pend_n[cand_idx] = 1'b0;
      pend_n = pend_n | set_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_n;
   end

   irq_svc_track #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_svc (
      .clk(clk), .rst_n(rst_n), .push(take), .push_idx(cand_idx), .pop(irq_rti),
      .insvc(in_service), .busy(svc_busy), .cur_idx(svc_cur)
   );

   assign pending = pend_q;

   // R3: an offered slot is unmasked or non-maskable
   a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (mask_q[irq_slot] || NMI_SLOTS[irq_slot]));

   // R4: with servicing disabled only bypass slots may be offered
   a_r4_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && !gie_q |-> GIE_BYPASS[irq_slot]);

   // R8: sequential mode offers nothing during a service
   a_r8_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      !nest_q && svc_busy |-> !irq_valid);

   // R8: preemption only by a strictly higher priority
   a_r8_strict: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && svc_busy |-> irq_slot < svc_cur);

   // R7: acknowledged slot leaves pending unless re-set in that cycle
   a_r7_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      take && !wr_pend && !set_vec[irq_slot] |=> !pend_q[$past(irq_slot)]);
endmodule

// File: tb/tb_irq_ctrl_top.sv
`timescale 1ns/1ps
module tb_irq_ctrl_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  core_req = '0;
   logic [14:0] periph_req = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        irq_ack = 1'b0;
   logic        irq_rti = 1'b0;
   logic        irq_valid;
   logic [3:0]  irq_slot;
   logic [23:0] irq_vec;
   logic [15:0] pending;
   logic [15:0] in_service;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_ctrl_top dut (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .periph_req(periph_req),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack), .irq_rti(irq_rti),
      .irq_valid(irq_valid), .irq_slot(irq_slot), .irq_vec(irq_vec),
      .pending(pending), .in_service(in_service)
   );

   // ---------------- behavioural reference model ----------------
   bit [15:0] m_pend, m_mask, m_insvc, m_prev, m_slot_in, m_set, n_pend, n_insvc;
   bit        m_nest, m_gie, m_v;
   int        m_s;

   function automatic void m_present(output bit v, output int s);
      bit [15:0] elig;
      int cur;
      elig = m_pend & (m_mask | 16'h0007) & (m_gie ? 16'hFFFF : 16'h0003);
      s = -1;
      for (int i = 0; i < 16; i++) if (elig[i] && s < 0) s = i;
      cur = 16;
      for (int i = 15; i >= 0; i--) if (m_insvc[i]) cur = i;
      v = (s >= 0) && (m_insvc == 0 || (m_nest && s < cur));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = '0; m_mask = '0; m_insvc = '0; m_prev = '0; m_nest = 0; m_gie = 0;
      end else begin
         m_present(m_v, m_s);
         m_slot_in = '0;
         for (int c = 0; c < 4; c++) m_slot_in[c] = core_req[c];
         for (int p = 0; p < 15; p++) if (periph_req[p]) m_slot_in[(p < 11) ? 4 + p : 15] = 1'b1;
         m_set  = m_slot_in & ~m_prev;
         m_prev = m_slot_in;
         n_pend = (wr_en && wr_sel == 2'd2) ? wr_data : m_pend;
         if (irq_ack && m_v) n_pend[m_s] = 1'b0;
         n_pend = n_pend | m_set;
         n_insvc = m_insvc;
         if (irq_rti) begin
            for (int i = 0; i < 16; i++) if (n_insvc[i]) begin n_insvc[i] = 1'b0; break; end
         end
         if (irq_ack && m_v) n_insvc[m_s] = 1'b1;
         if (wr_en && wr_sel == 2'd0) begin m_nest = wr_data[4]; m_gie = wr_data[5]; end
         if (wr_en && wr_sel == 2'd1) m_mask = wr_data;
         m_pend  = n_pend;
         m_insvc = n_insvc;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin
      bit v; int s;
      if (rst_n && !done) begin
         m_present(v, s);
         chk("R8 model irq_valid", 32'(irq_valid), 32'(v));
         chk("R5 model irq_slot", 32'(irq_slot), v ? 32'(s) : 32'd0);
         chk("R5 model irq_vec", 32'(irq_vec), v ? 32'(s) * 32'h20 : 32'd0);
         chk("R2 model pending", 32'(pending), 32'(m_pend));
         chk("R7 model in_service", 32'(in_service), 32'(m_insvc));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic ack();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
   endtask

   task automatic rti();
      irq_rti = 1'b1; tick(); irq_rti = 1'b0;
   endtask

   task automatic pulse_core(input int c);
      core_req[c] = 1'b1; tick(); core_req[c] = 1'b0;
   endtask

   task automatic pulse_periph(input int p);
      periph_req[p] = 1'b1; tick(); periph_req[p] = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 irq_valid", 32'(irq_valid), 0);
      chk("R1 pending", 32'(pending), 0);
      chk("R1 in_service", 32'(in_service), 0);

      // R2 peripheral 0 lands in slot 4; R4 global enable off blocks it
      pulse_periph(0);
      chk("R2 periph0 slot4", 32'(pending), 32'h0010);
      chk("R4 gie off", 32'(irq_valid), 0);
      pulse_core(2);
      chk("R4 power-down held back", 32'(irq_valid), 0);
      pulse_core(1);
      chk("R4 reset slot bypass", 32'(irq_valid), 1);
      chk("R5 slot1 vec", 32'(irq_vec), 32'h20);

      // R7 acknowledge
      ack();
      chk("R7 pending cleared", 32'(pending), 32'h0014);
      chk("R7 in_service set", 32'(in_service), 32'h0002);
      chk("R8 sequential nothing offered", 32'(irq_valid), 0);
      rti();
      chk("R9 return clears", 32'(in_service), 0);

      // R4/R3 enable: slot 2 ignores zero mask
      wr(2'd0, 16'h0020);
      chk("R3 non-maskable slot2", 32'(irq_slot), 2);
      ack(); rti();
      chk("R3 masked slot4", 32'(irq_valid), 0);
      wr(2'd1, 16'hFFFF);
      chk("R5 slot4 vec", 32'(irq_vec), 32'h80);

      // R8 sequential; R2 shared slot 15
      ack();
      pulse_periph(13);
      chk("R2 periph13 slot15", 32'(pending), 32'h8000);
      chk("R8 no preempt sequential", 32'(irq_valid), 0);
      rti();
      chk("R5 slot15 vec", 32'(irq_vec), 32'h1E0);
      ack();
      ack();
      chk("R7 ack ignored when idle", 32'(in_service), 32'h8000);
      rti();

      // R6 force and clear
      wr(2'd2, 16'h0300);
      chk("R6 force", 32'(pending), 32'h0300);
      chk("R5 slot8 vec", 32'(irq_vec), 32'h100);
      wr(2'd2, 16'h0000);
      chk("R6 clear", 32'(pending), 0);
      chk("R6 clear nothing offered", 32'(irq_valid), 0);

      // R8 nesting
      wr(2'd0, 16'h0030);
      wr(2'd2, 16'h0400);
      ack();
      wr(2'd2, 16'h0008);
      chk("R8 preempt slot3", 32'(irq_slot), 3);
      ack();
      chk("R8 nested in_service", 32'(in_service), 32'h0408);
      wr(2'd2, 16'h1000);
      chk("R8 lower priority held", 32'(irq_valid), 0);
      rti();
      chk("R9 level restored", 32'(in_service), 32'h0400);
      chk("R8 still held", 32'(irq_valid), 0);
      rti();
      chk("R9 idle then offered", 32'(irq_slot), 12);
      wr(2'd2, 16'h0000);

      // R2 held request latches once
      periph_req[5] = 1'b1;
      tick();
      chk("R2 held sets", 32'(pending), 32'h0200);
      wr(2'd2, 16'h0000);
      tick(); tick();
      chk("R2 held no relatch", 32'(pending), 0);
      periph_req[5] = 1'b0;

      // R10 reserved bits and unused select
      wr(2'd0, 16'hFFCF);
      wr(2'd2, 16'h0010);
      chk("R10 reserved bits ignored", 32'(irq_valid), 0);
      wr(2'd3, 16'hFFFF);
      chk("R10 select 3 no write", 32'(pending), 32'h0010);
      chk("R10 select 3 keeps gie off", 32'(irq_valid), 0);
      wr(2'd2, 16'h0000);

      // mixed traffic against the model
      for (int k = 0; k < 600; k++) begin
         core_req   = 4'($urandom);
         periph_req = 15'($urandom) & 15'($urandom);
         irq_ack    = ($urandom % 3) == 0;
         irq_rti    = ($urandom % 4) == 0;
         wr_en      = ($urandom % 6) == 0;
         wr_sel     = 2'($urandom);
         wr_data    = 16'($urandom);
         tick();
      end
      finish_run();
   end
endmodule